// File: doc/BRIEF.md
# Multi-Mode Capture/Compare Channel

This block is one capture/compare channel that watches a free-running 16-bit counter supplied from outside. An 8-bit mode register holds one bit per function, and the channel turns those bits into one of six behaviours. It can latch the counter on an edge of an input pin, raise a flag when the counter reaches a programmed value, toggle an output pin on such a match, generate a square wave whose half-period is the high compare byte, or drive a pulse-width-modulated output. The PWM period is either 16 bits or 8 to 11 bits, picked by a 2-bit length selector.

Software reaches the 16-bit compare value through a low/high byte write pair and a 16-bit read port. In 9-, 10- and 11-bit PWM, a select input sends that same byte pair to a reload register instead. The reload value is copied into the compare register at every period wrap. A hit flag and a wrap flag are each set by hardware and written by software. An interrupt request combines each flag with its own enable. The cycle-length selector, the reload select and the wrap-interrupt enable are inputs, because they are shared with other channels.

Top module: `ccp_channel`

## Requirements
- R1: After a synchronous reset the mode register, compare value, reload value, output pin, both flags and the interrupt request are all 0.
- R2: Mode bits are, from bit 7 down to bit 0: wide PWM, comparator enable, capture on rise, capture on fall, match, toggle, PWM, interrupt enable. With PWM, toggle and match clear and bit 5 and/or bit 4 set, an edge of the selected polarity on `pin_in` loads the current counter value into the compare register and sets `hit_flag`. The pin passes two synchronising flops, so a level driven before clock edge k is captured at edge k+2 with the counter value present at that edge.
- R3: Every compare event needs comparator enable (bit 6) and a counter value different from the previous cycle. With match set and toggle and PWM clear (software timer), a full 16-bit match sets `hit_flag` one clock later and leaves `pin_out` unchanged.
- R4: With toggle set and PWM clear (high-speed output), each full 16-bit match inverts `pin_out` and sets `hit_flag`. With comparator enable clear, the pin holds and the flag is not set.
- R5: With PWM and toggle set and wide PWM clear (frequency output), each match of the counter's low byte against the compare low byte inverts `pin_out` and adds the compare high byte to the compare low byte, modulo 256. `hit_flag` is not set.
- R6: In narrow PWM (PWM=1, toggle=0, wide=0), N = 8 + `len_sel`. A match of the low N bits drives `pin_out` high. A wrap of the low N bits (all ones to all zeros) drives it low. When both happen together the match wins, so a compare value of 0 gives a constant high.
- R7: In narrow PWM with `len_sel` nonzero, `reload_sel`=1 routes the byte writes and `dat_rdata` to the reload register. At each N-bit wrap the reload value is copied into the compare register. With `len_sel`=0 or in any other mode the select is ignored and the compare register is used.
- R8: In wide PWM (bits 7 and 1 set), a full 16-bit match drives `pin_out` high and the `cnt_wrap` strobe drives it low, with the match winning.
- R9: In either PWM mode with comparator enable clear, `pin_out` is 0 from the next clock on.
- R10: With the match bit set, a PWM match sets `hit_flag`. `irq` is high when `hit_flag` and mode bit 0 are both set, or when `wrap_flag` and `wrap_ie` are both set.
- R11: In every mode, a wrap of the counter's low N bits, with N from `len_sel`, sets `wrap_flag`.
- R12: A `flag_we` write loads `hit_flag` from `flag_wdata[0]` and `wrap_flag` from `flag_wdata[1]`. A hardware set in the same cycle wins over a written 0. A capture, frequency advance or reload in the same cycle wins over a compare-register byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Current counter value |
| cnt_wrap | input | 1 | Strobe in the cycle the 16-bit counter wraps to 0 |
| pin_in | input | 1 | Asynchronous capture input |
| pin_out | output | 1 | Registered waveform output |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_q | output | 8 | Mode register contents |
| len_sel | input | 2 | Shared PWM length select, N = 8 + value |
| reload_sel | input | 1 | Routes data access to the reload register (narrow PWM, N > 8) |
| wrap_ie | input | 1 | Wrap-flag interrupt enable |
| dat_wr_lo | input | 1 | Write low byte of the selected register |
| dat_wr_hi | input | 1 | Write high byte of the selected register |
| dat_wdata | input | 8 | Byte write data |
| dat_rdata | output | 16 | Selected register read data |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Bit 0 hit flag, bit 1 wrap flag |
| hit_flag | output | 1 | Match/capture flag |
| wrap_flag | output | 1 | N-bit wrap flag |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions get directed coverage. The first is a software clear of the hit flag in the cycle where the counter reaches the compare value: the flag must end up set. The second is a narrow-PWM period wrap that falls on a compare match, which happens when the compare value is 0: the pin must stay high. The collision test sets the counter so the match falls exactly in the write cycle. Random stimulus then scatters flag clears and counter stalls over all modes. A bench model computes the flags, pin and read data from the requirements every cycle and compares them.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int MB_WIDE   = 7;
  localparam int MB_CMPEN  = 6;
  localparam int MB_RISE   = 5;
  localparam int MB_FALL   = 4;
  localparam int MB_MATCH  = 3;
  localparam int MB_TOGGLE = 2;
  localparam int MB_PWM    = 1;
  localparam int MB_IE     = 0;

  typedef enum logic [2:0] {
    CM_IDLE, CM_CAPT, CM_TIMER, CM_HSO, CM_FREQ, CM_PWMN, CM_PWMW
  } ccp_mode_e;

  function automatic ccp_mode_e ccp_decode(input logic [7:0] m);
    ccp_mode_e r;
    if (m[MB_PWM]) begin
      if (m[MB_WIDE])        r = CM_PWMW;
      else if (m[MB_TOGGLE]) r = CM_FREQ;
      else                   r = CM_PWMN;
    end else if (m[MB_TOGGLE])          r = CM_HSO;
    else if (m[MB_MATCH])               r = CM_TIMER;
    else if (m[MB_RISE] | m[MB_FALL])   r = CM_CAPT;
    else                                r = CM_IDLE;
    return r;
  endfunction
endpackage

// File: rtl/ccp_mode_reg.sv
module ccp_mode_reg
  import ccp_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [MW-1:0] wdata,
  output logic [MW-1:0] mode_q,
  output ccp_mode_e     mode_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      mode_sel <= CM_IDLE;
    end else if (we) begin
      mode_q   <= wdata;
      mode_sel <= ccp_decode(wdata[7:0]);
    end
  end
endmodule

// File: rtl/ccp_edge_sync.sv
module ccp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh[0] <= 1'b0;
    else     sh[0] <= din;
  end

  genvar i;
  generate
    for (i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sh[i] <= 1'b0;
        else     sh[i] <= sh[i-1];
      end
    end
  endgenerate

  assign rise =  sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/ccp_cmp_store.sv
module ccp_cmp_store #(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  input  logic          arl_sel,
  input  logic          cap_ev,
  input  logic [CW-1:0] cap_val,
  input  logic          adv_ev,
  input  logic          reload_ev,
  output logic [CW-1:0] cmp_q,
  output logic [CW-1:0] arl_q,
  output logic [CW-1:0] rdata
);
  localparam int HB = CW - BW;

  logic [BW-1:0] adv_lo;
  assign adv_lo = cmp_q[BW-1:0] + cmp_q[CW-1:HB];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
    end else if (cap_ev) begin
      cmp_q <= cap_val;
    end else if (adv_ev) begin
      cmp_q[BW-1:0] <= adv_lo;
    end else if (reload_ev) begin
      cmp_q <= arl_q;
    end else if (!arl_sel) begin
      if (wr_lo) cmp_q[BW-1:0] <= wdata;
      if (wr_hi) cmp_q[CW-1:HB] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arl_q <= '0;
    end else if (arl_sel) begin
      if (wr_lo) arl_q[BW-1:0] <= wdata;
      if (wr_hi) arl_q[CW-1:HB] <= wdata;
    end
  end

  assign rdata = arl_sel ? arl_q : cmp_q;
endmodule

// File: rtl/ccp_wave.sv
module ccp_wave
  import ccp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ccp_mode_e mode_sel,
  input  logic      cmp_en,
  input  logic      match_on,
  input  logic      match_full,
  input  logic      match_lo,
  input  logic      match_n,
  input  logic      wrap_n,
  input  logic      wrap_full,
  input  logic      cap_ev,
  input  logic      flag_we,
  input  logic [1:0] flag_wdata,
  output logic      pin_q,
  output logic      hit_q,
  output logic      wrap_q
);
  logic pin_d, hit_set;

  always_comb begin
    pin_d = pin_q;
    unique case (mode_sel)
      CM_HSO:  if (match_full) pin_d = ~pin_q;
      CM_FREQ: if (match_lo)   pin_d = ~pin_q;
      CM_PWMN: begin
        if (!cmp_en)      pin_d = 1'b0;
        else if (match_n) pin_d = 1'b1;
        else if (wrap_n)  pin_d = 1'b0;
      end
      CM_PWMW: begin
        if (!cmp_en)         pin_d = 1'b0;
        else if (match_full) pin_d = 1'b1;
        else if (wrap_full)  pin_d = 1'b0;
      end
      default: pin_d = pin_q;
    endcase
  end

  always_comb begin
    hit_set = cap_ev;
    if (match_on) begin
      unique case (mode_sel)
        CM_TIMER, CM_HSO, CM_PWMW: hit_set = hit_set | match_full;
        CM_PWMN:                   hit_set = hit_set | match_n;
        default:                   hit_set = hit_set;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      hit_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
      if (hit_set)      hit_q <= 1'b1;
      else if (flag_we) hit_q <= flag_wdata[0];
      if (wrap_n)       wrap_q <= 1'b1;
      else if (flag_we) wrap_q <= flag_wdata[1];
    end
  end
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
  import ccp_pkg::*;
#(
  parameter int CW          = 16,
  parameter int BW          = 8,
  parameter int MW          = 8,
  parameter int MIN_PWM     = 8,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    cnt_val,
  input  logic             cnt_wrap,
  input  logic             pin_in,
  output logic             pin_out,
  input  logic             mode_we,
  input  logic [MW-1:0]    mode_wdata,
  output logic [MW-1:0]    mode_q,
  input  logic [SEL_W-1:0] len_sel,
  input  logic             reload_sel,
  input  logic             wrap_ie,
  input  logic             dat_wr_lo,
  input  logic             dat_wr_hi,
  input  logic [BW-1:0]    dat_wdata,
  output logic [CW-1:0]    dat_rdata,
  input  logic             flag_we,
  input  logic [1:0]       flag_wdata,
  output logic             hit_flag,
  output logic             wrap_flag,
  output logic             irq
);
  localparam int NSEL = 1 << SEL_W;

  ccp_mode_e     mode_sel;
  logic [CW-1:0] cnt_prev, cmp_q, arl_q, cur_mask;
  logic [CW-1:0] mask_tab [NSEL];
  logic          cmp_en, cnt_chg, match_full, match_lo, match_n, wrap_n;
  logic          rise, fall, cap_ev, adv_ev, reload_ev, arl_sel, wide_len;

  genvar g;
  generate
    for (g = 0; g < NSEL; g++) begin : g_mask
      assign mask_tab[g] = CW'((64'd1 << (MIN_PWM + g)) - 64'd1);
    end
  endgenerate
  assign cur_mask = mask_tab[len_sel];

  ccp_mode_reg #(.MW(MW)) u_mode (
    .clk(clk), .rst(rst), .we(mode_we), .wdata(mode_wdata),
    .mode_q(mode_q), .mode_sel(mode_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) cnt_prev <= '0;
    else     cnt_prev <= cnt_val;
  end

  assign cmp_en     = mode_q[MB_CMPEN];
  assign cnt_chg    = cnt_val != cnt_prev;
  assign match_full = cmp_en & cnt_chg & (cnt_val == cmp_q);
  assign match_lo   = cmp_en & cnt_chg & (cnt_val[BW-1:0] == cmp_q[BW-1:0]);
  assign match_n    = cmp_en & cnt_chg & ((cnt_val & cur_mask) == (cmp_q & cur_mask));
  assign wrap_n     = cnt_chg & ((cnt_prev & cur_mask) == cur_mask)
                    & ((cnt_val & cur_mask) == '0);

  ccp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .rise(rise), .fall(fall)
  );

  assign wide_len  = len_sel != '0;
  assign cap_ev    = (mode_sel == CM_CAPT)
                   & ((mode_q[MB_RISE] & rise) | (mode_q[MB_FALL] & fall));
  assign adv_ev    = (mode_sel == CM_FREQ) & match_lo;
  assign reload_ev = (mode_sel == CM_PWMN) & wide_len & wrap_n;
  assign arl_sel   = reload_sel & (mode_sel == CM_PWMN) & wide_len;

  ccp_cmp_store #(.CW(CW), .BW(BW)) u_store (
    .clk(clk), .rst(rst), .wr_lo(dat_wr_lo), .wr_hi(dat_wr_hi),
    .wdata(dat_wdata), .arl_sel(arl_sel), .cap_ev(cap_ev), .cap_val(cnt_val),
    .adv_ev(adv_ev), .reload_ev(reload_ev), .cmp_q(cmp_q), .arl_q(arl_q),
    .rdata(dat_rdata)
  );

  ccp_wave u_wave (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .cmp_en(cmp_en),
    .match_on(mode_q[MB_MATCH]), .match_full(match_full), .match_lo(match_lo),
    .match_n(match_n), .wrap_n(wrap_n), .wrap_full(cnt_wrap), .cap_ev(cap_ev),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .pin_q(pin_out),
    .hit_q(hit_flag), .wrap_q(wrap_flag)
  );

  assign irq = (hit_flag & mode_q[MB_IE]) | (wrap_flag & wrap_ie);
endmodule

// File: rtl/ccp_channel_chk.sv
module ccp_channel_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  mode_q,
  input logic [15:0] cnt_val,
  input logic        flag_we,
  input logic [1:0]  flag_wdata,
  input logic        pin_out,
  input logic        hit_flag,
  input logic        wrap_flag,
  input logic        wrap_ie,
  input logic        irq
);
  // R2 and R3: capture, timer and idle modes never move the pin
  p_pin_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_q[1] && !mode_q[2]) |=> $stable(pin_out));

  p_hso_off_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q[2] && !mode_q[1] && !mode_q[6]) |=> $stable(pin_out));

  p_pwm_off_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_q[1] && (mode_q[7] || !mode_q[2]) && !mode_q[6]) |=> !pin_out);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (!mode_q[0] && !wrap_ie) |-> !irq);

  p_wrap_src_r11: assert property (@(posedge clk) disable iff (rst)
    ($rose(wrap_flag) && !$past(flag_we)) |-> ($past(cnt_val[7:0]) == 8'd0));

  p_flag_clr_r12: assert property (@(posedge clk) disable iff (rst)
    (flag_we && !flag_wdata[0] && !mode_q[6] && !mode_q[5] && !mode_q[4])
      |=> !hit_flag);
endmodule

bind ccp_channel ccp_channel_chk u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .cnt_val(cnt_val),
  .flag_we(flag_we), .flag_wdata(flag_wdata), .pin_out(pin_out),
  .hit_flag(hit_flag), .wrap_flag(wrap_flag), .wrap_ie(wrap_ie), .irq(irq)
);

// File: tb/sim_ccp_channel.sv
module sim_ccp_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt_val = '0;
  logic        cnt_wrap = 1'b0;
  logic        pin_in = 1'b0;
  logic        pin_out;
  logic        mode_we = 1'b0;
  logic [7:0]  mode_wdata = '0;
  logic [7:0]  mode_q;
  logic [1:0]  len_sel = '0;
  logic        reload_sel = 1'b0;
  logic        wrap_ie = 1'b0;
  logic        dat_wr_lo = 1'b0;
  logic        dat_wr_hi = 1'b0;
  logic [7:0]  dat_wdata = '0;
  logic [15:0] dat_rdata;
  logic        flag_we = 1'b0;
  logic [1:0]  flag_wdata = '0;
  logic        hit_flag, wrap_flag, irq;

  always #5 clk = ~clk;

  ccp_channel u0 (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_wrap(cnt_wrap),
    .pin_in(pin_in), .pin_out(pin_out), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .mode_q(mode_q), .len_sel(len_sel),
    .reload_sel(reload_sel), .wrap_ie(wrap_ie), .dat_wr_lo(dat_wr_lo),
    .dat_wr_hi(dat_wr_hi), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .hit_flag(hit_flag),
    .wrap_flag(wrap_flag), .irq(irq)
  );

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  string cur_req = "R1";
  bit    hold_en = 1'b0;

  typedef enum int {K_IDLE, K_CAPT, K_TIMER, K_HSO, K_FREQ, K_PWMN, K_PWMW} kind_e;

  function automatic kind_e kind_of(input logic [7:0] m);
    if (m[1]) return m[7] ? K_PWMW : (m[2] ? K_FREQ : K_PWMN);
    if (m[2]) return K_HSO;
    if (m[3]) return K_TIMER;
    if (m[5] || m[4]) return K_CAPT;
    return K_IDLE;
  endfunction

  // Bench model, written from the requirements
  logic [7:0]  m_mode = '0;
  logic [15:0] m_cmp = '0, m_arl = '0, m_prev = '0;
  logic        m_pin = 0, m_hit = 0, m_wrap = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0;

  function automatic logic route_arl(input logic [7:0] m, input logic [1:0] ls,
                                     input logic rs);
    return rs && kind_of(m) == K_PWMN && ls != 2'd0;
  endfunction

  always @(posedge clk) begin : model
    kind_e       k;
    logic [15:0] mask, n_cmp, n_arl;
    logic        en, chg, mt16, mlo, mn, wrn, cap, ar, n_pin, n_hit, n_wrap;
    if (rst) begin
      m_mode = '0; m_cmp = '0; m_arl = '0; m_prev = '0;
      m_pin = 0; m_hit = 0; m_wrap = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      k    = kind_of(m_mode);
      en   = m_mode[6];
      mask = 16'((32'd1 << (8 + len_sel)) - 32'd1);
      chg  = cnt_val != m_prev;
      mt16 = en && chg && cnt_val == m_cmp;
      mlo  = en && chg && cnt_val[7:0] == m_cmp[7:0];
      mn   = en && chg && (cnt_val & mask) == (m_cmp & mask);
      wrn  = chg && (m_prev & mask) == mask && (cnt_val & mask) == 16'd0;
      cap  = k == K_CAPT && ((m_mode[5] && m_s2 && !m_s3) || (m_mode[4] && !m_s2 && m_s3));
      ar   = route_arl(m_mode, len_sel, reload_sel);
      n_cmp = m_cmp; n_arl = m_arl;
      if (cap) n_cmp = cnt_val;
      else if (k == K_FREQ && mlo) n_cmp[7:0] = m_cmp[7:0] + m_cmp[15:8];
      else if (k == K_PWMN && len_sel != 0 && wrn) n_cmp = m_arl;
      else if (!ar) begin
        if (dat_wr_lo) n_cmp[7:0] = dat_wdata;
        if (dat_wr_hi) n_cmp[15:8] = dat_wdata;
      end
      if (ar) begin
        if (dat_wr_lo) n_arl[7:0] = dat_wdata;
        if (dat_wr_hi) n_arl[15:8] = dat_wdata;
      end
      n_pin = m_pin;
      case (k)
        K_HSO:  if (mt16) n_pin = !m_pin;
        K_FREQ: if (mlo) n_pin = !m_pin;
        K_PWMN: if (!en) n_pin = 0; else if (mn) n_pin = 1; else if (wrn) n_pin = 0;
        K_PWMW: if (!en) n_pin = 0; else if (mt16) n_pin = 1; else if (cnt_wrap) n_pin = 0;
        default: n_pin = m_pin;
      endcase
      n_hit = flag_we ? flag_wdata[0] : m_hit;
      if (cap || (m_mode[3] && (((k == K_TIMER || k == K_HSO || k == K_PWMW) && mt16) ||
                                (k == K_PWMN && mn)))) n_hit = 1;
      n_wrap = flag_we ? flag_wdata[1] : m_wrap;
      if (wrn) n_wrap = 1;
      m_cmp = n_cmp; m_arl = n_arl; m_pin = n_pin; m_hit = n_hit; m_wrap = n_wrap;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in; m_prev = cnt_val;
      if (mode_we) m_mode = mode_wdata;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [15:0] rd_exp;
    rd_exp = route_arl(m_mode, len_sel, reload_sel) ? m_arl : m_cmp;
    chk(cur_req, "pin_out", 32'(pin_out), 32'(m_pin));
    chk(cur_req, "hit_flag", 32'(hit_flag), 32'(m_hit));
    chk("R11", "wrap_flag", 32'(wrap_flag), 32'(m_wrap));
    chk("R10", "irq", 32'(irq), 32'((m_hit && m_mode[0]) || (m_wrap && wrap_ie)));
    chk(cur_req, "dat_rdata", 32'(dat_rdata), 32'(rd_exp));
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    dat_wr_lo = 0; dat_wr_hi = 0; flag_we = 0; mode_we = 0;
    if (hold_en && ($urandom % 4) == 0) cnt_wrap = 0;
    else {cnt_wrap, cnt_val} = {1'b0, cnt_val} + 17'd1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      if (($urandom % 23) == 0) begin flag_we = 1; flag_wdata = 2'(($urandom % 4)); end
      step();
    end
  endtask

  task automatic set_mode(input logic [7:0] m);
    mode_we = 1; mode_wdata = m; step();
  endtask

  task automatic wr_dat(input logic [15:0] v);
    dat_wr_lo = 1; dat_wdata = v[7:0]; step();
    dat_wr_hi = 1; dat_wdata = v[15:8]; step();
  endtask

  task automatic set_cnt(input logic [15:0] v);
    cnt_val = v; cnt_wrap = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 120000) begin
      failures++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cycles, 120000);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "pin_out", 32'(pin_out), 0);
    chk("R1", "hit_flag", 32'(hit_flag), 0);
    chk("R1", "wrap_flag", 32'(wrap_flag), 0);
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "dat_rdata", 32'(dat_rdata), 0);
    chk("R1", "mode_q", 32'(mode_q), 0);

    // R2 directed capture timing
    cur_req = "R2";
    set_mode(8'h21);
    set_cnt(16'h1230); pin_in = 1;
    step(); step(); step();
    chk("R2", "captured value", 32'(dat_rdata), 32'h1232);
    chk("R2", "hit after capture", 32'(hit_flag), 1);
    hold_en = 1;
    foreach (cap_modes[j]) begin
      set_mode(cap_modes[j]);
      for (int i = 0; i < 150; i++) begin
        if (($urandom % 6) == 0) pin_in = ~pin_in;
        if (($urandom % 20) == 0) begin flag_we = 1; flag_wdata = 2'b00; end
        step();
      end
    end

    // R3 software timer
    cur_req = "R3";
    set_mode(8'h49);
    for (int i = 0; i < 4; i++) begin
      logic [15:0] v;
      v = 16'($urandom);
      wr_dat(v); set_cnt(v - 16'd10); run(40);
    end

    // R4 high-speed output, comparator on then off
    cur_req = "R4";
    wrap_ie = 1;
    foreach (hso_modes[j]) begin
      set_mode(hso_modes[j]);
      for (int i = 0; i < 3; i++) begin
        wr_dat(16'h2000 + 16'(i * 7)); set_cnt(16'h1FF0); run(40);
      end
    end
    wrap_ie = 0;

    // R5 frequency output
    cur_req = "R5";
    hold_en = 0;
    set_mode(8'h47);
    wr_dat({8'd5, 8'd20}); set_cnt(16'd0); run(600);
    wr_dat({8'd200, 8'd3}); run(600);

    // R6 and R7 narrow PWM with reload
    for (int c = 0; c < 4; c++) begin
      cur_req = (c == 0) ? "R6" : "R7";
      len_sel = 2'(c);
      reload_sel = 0;
      set_mode(8'h4B);
      wr_dat(16'($urandom) & 16'((32'd1 << (8 + c)) - 1));
      reload_sel = 1;
      wr_dat(16'($urandom) & 16'((32'd1 << (8 + c)) - 1));
      set_cnt(16'd0);
      run(3 * (256 << c));
      reload_sel = 0;
    end
    // R6 compare value 0: match and wrap coincide, pin stays high
    cur_req = "R6";
    len_sel = 0;
    wr_dat(16'd0); set_cnt(16'd0);
    run(300);
    chk("R6", "zero compare high", 32'(pin_out), 1);
    step();
    chk("R6", "zero compare stays high", 32'(pin_out), 1);

    // R8 wide PWM across a 16-bit wrap
    cur_req = "R8";
    hold_en = 1;
    set_mode(8'hCB);
    wr_dat(16'hFF80); set_cnt(16'hFF00); run(600);

    // R9 PWM with comparator off
    cur_req = "R9";
    set_mode(8'h0B); run(300);
    chk("R9", "narrow off low", 32'(pin_out), 0);
    set_mode(8'hCB); run(30);
    set_mode(8'h8B); run(300);
    chk("R9", "wide off low", 32'(pin_out), 0);

    // R10 and R11 interrupt gating with wrap enable
    cur_req = "R10";
    wrap_ie = 1;
    len_sel = 2'd1;
    set_mode(8'h00); set_cnt(16'h01F0); run(100);
    cur_req = "R11";
    set_mode(8'h4A); run(700);
    wrap_ie = 0;

    // R12 clear colliding with a match
    cur_req = "R12";
    hold_en = 0;
    set_mode(8'h49);
    wr_dat(16'h0100);
    flag_we = 1; flag_wdata = 2'b00; step();
    set_cnt(16'h00FF); step();
    flag_we = 1; flag_wdata = 2'b00; step();
    chk("R12", "set beats clear", 32'(hit_flag), 1);
    flag_we = 1; flag_wdata = 2'b00; step();
    chk("R12", "plain clear", 32'(hit_flag), 0);
    // capture beats a byte write in the same cycle
    set_mode(8'h21);
    pin_in = 0; run(4);
    set_cnt(16'h4440); pin_in = 1;
    step(); step();
    dat_wr_lo = 1; dat_wdata = 8'hAA; step();
    chk("R12", "capture beats write", 32'(dat_rdata), 32'h4442);

    summary();
    $finish;
  end

  logic [7:0] cap_modes [3] = '{8'h21, 8'h11, 8'h31};
  logic [7:0] hso_modes [2] = '{8'h4D, 8'h0D};
endmodule